// File: doc/BRIEF.md
# Peripheral-Shared GPIO Port Controller

A parallel I/O port of configurable width in which every pin is shared between a general-purpose port bit and an on-chip peripheral. Software reaches three views of the port over a small register bus: a direction register, an output latch and a pin-state view. The pin-state view reads the synchronized pin levels, and a write to it lands in the latch. Each pin has an ownership multiplexer. Whenever the peripheral is enabled on that pin and is asserting its own output enable, the peripheral drives the pin. Otherwise the port drives it according to its direction and latch bits.

The synchronized pin level is returned both to the register read path and to the peripheral. When the port itself drives a pin, the peripheral input for that pin is forced low, so that port output never loops back into the peripheral. A per-port implementation mask selects which bits exist. Bits outside the mask read as zero, drive nothing and ignore writes. Pads are outside the block: pins appear as separate input, output and output-enable vectors.

Top module: `gpio_share_port`

## Requirements
- R1: While rst_ni is low, every implemented direction bit is 1 and every latch bit is 0, and the synchronizer holds 0. This applies even when wr_en_i is high during reset.
- R2: A direction bit of 1 makes the pin an input: the port does not enable the pin. A direction bit of 0 makes it an output that drives the latch bit, provided the peripheral does not own the pin. A write with sel_i = 0 loads the direction register.
- R3: Register select codes are 0 = direction, 1 = pin state, 2 = latch. Reads are combinational while rd_en_i is high. Select 3 reads 0, and rdata_o is 0 while rd_en_i is low.
- R4: A write with sel_i = 2 updates the latch on the rising clock edge, and a read with sel_i = 2 returns the stored latch.
- R5: A write with sel_i = 1 updates the latch and not the pins. A read with sel_i = 1 returns the synchronized pin levels.
- R6: When periph_en_i and periph_oe_i are both 1 for an implemented pin, pin_oe_o is 1 and pin_out_o follows periph_out_i for that pin. The pin remains readable with sel_i = 1.
- R7: When periph_en_i is 1 but periph_oe_i is 0 for a pin, the port drives that pin from its direction and latch bits.
- R8: Bits outside IMPL_MASK read 0 in every register view, have pin_oe_o, pin_out_o and periph_in_o equal to 0, and ignore writes.
- R9: When the port owns an enabled output on a pin, periph_in_o for that pin is 0. Otherwise periph_in_o follows the synchronized pin level.
- R10: Pin reads and periph_in_o reflect pin_in_i as sampled two rising edges earlier (two-flop synchronizer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| sel_i | input | 2 | Register select (0 dir, 1 pin, 2 latch) |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data |
| periph_en_i | input | W | Peripheral enabled, per pin |
| periph_oe_i | input | W | Peripheral output enable, per pin |
| periph_out_i | input | W | Peripheral output data, per pin |
| periph_in_o | output | W | Pin input returned to the peripheral |
| pin_in_i | input | W | Pin level from pad |
| pin_out_o | output | W | Pin output data to pad |
| pin_oe_o | output | W | Pin output enable to pad |

## Verification
The hardest case to reach from the ports is loop-through suppression. It needs a pin that the port actively drives as an output while the external level on that pin is high, next to a neighbouring pin that the peripheral owns at the same level. The bench sets up exactly that pair. It clears the direction bits, enables the peripheral on some bits but asserts its output enable on only a subset, and holds pin_in_i high for more than two edges. It then checks that periph_in_o carries the level only on the peripheral-owned bits, and that the pin-state read still shows every implemented pin. Long random runs with mid-run resets taken during write strobes then cover the remaining interleavings against the behavioural model.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_PIN  = 2'd1,
    SEL_LAT  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_share_regs.sv
module gpio_share_regs
  import gpio_share_pkg::*;
#(
  parameter int unsigned     W         = 16,
  parameter logic [W-1:0]    IMPL_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] dir_q, lat_q;
  logic         dir_we, lat_we;
  logic [W-1:0] wmask;

  assign wmask  = wdata_i & IMPL_MASK;
  assign dir_we = wr_en_i && (sel_i == SEL_DIR);
  // pin-state writes are redirected to the latch
  assign lat_we = wr_en_i && ((sel_i == SEL_LAT) || (sel_i == SEL_PIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= IMPL_MASK;
    end else if (dir_we) begin
      dir_q <= wmask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else if (lat_we) begin
      lat_q <= wmask;
    end
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/gpio_share_sync.sv
module gpio_share_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_chain
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_share_pinmux.sv
module gpio_share_pinmux #(
  parameter int unsigned  W         = 16,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] periph_en_i,
  input  logic [W-1:0] periph_oe_i,
  input  logic [W-1:0] periph_out_i,
  output logic [W-1:0] periph_in_o,
  output logic [W-1:0] pin_out_o,
  output logic [W-1:0] pin_oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (IMPL_MASK[i]) begin : g_impl
      logic periph_owns, port_drives;
      assign periph_owns  = periph_en_i[i] & periph_oe_i[i];
      assign port_drives  = ~periph_owns & ~dir_i[i];
      assign pin_oe_o[i]  = periph_owns | port_drives;
      assign pin_out_o[i] = periph_owns ? periph_out_i[i] : lat_i[i];
      // block loop-through of port output into peripheral input
      assign periph_in_o[i] = sync_i[i] & ~port_drives;
    end else begin : g_absent
      logic unused_bits;
      assign unused_bits    = ^{dir_i[i], lat_i[i], sync_i[i],
                                periph_en_i[i], periph_oe_i[i], periph_out_i[i]};
      assign pin_oe_o[i]    = 1'b0;
      assign pin_out_o[i]   = 1'b0;
      assign periph_in_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_share_rdmux.sv
module gpio_share_rdmux
  import gpio_share_pkg::*;
#(
  parameter int unsigned  W         = 16,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         rd_en_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] sel_data;

  always_comb begin
    unique case (sel_i)
      SEL_DIR:  sel_data = dir_i;
      SEL_PIN:  sel_data = sync_i;
      SEL_LAT:  sel_data = lat_i;
      default:  sel_data = '0;
    endcase
  end

  assign rdata_o = rd_en_i ? (sel_data & IMPL_MASK) : '0;
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_share_pkg::*;
#(
  parameter int unsigned  W           = 16,
  parameter logic [W-1:0] IMPL_MASK   = 16'h7BFF,
  parameter int unsigned  SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] periph_en_i,
  input  logic [W-1:0] periph_oe_i,
  input  logic [W-1:0] periph_out_i,
  output logic [W-1:0] periph_in_o,
  input  logic [W-1:0] pin_in_i,
  output logic [W-1:0] pin_out_o,
  output logic [W-1:0] pin_oe_o
);
  reg_sel_e     sel;
  logic [W-1:0] dir_q, lat_q, sync_q;

  assign sel = reg_sel_e'(sel_i);

  gpio_share_regs #(.W(W), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .dir_o   (dir_q),
    .lat_o   (lat_q)
  );

  gpio_share_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (sync_q)
  );

  gpio_share_pinmux #(.W(W), .IMPL_MASK(IMPL_MASK)) u_pinmux (
    .dir_i        (dir_q),
    .lat_i        (lat_q),
    .sync_i       (sync_q),
    .periph_en_i  (periph_en_i),
    .periph_oe_i  (periph_oe_i),
    .periph_out_i (periph_out_i),
    .periph_in_o  (periph_in_o),
    .pin_out_o    (pin_out_o),
    .pin_oe_o     (pin_oe_o)
  );

  gpio_share_rdmux #(.W(W), .IMPL_MASK(IMPL_MASK)) u_rdmux (
    .rd_en_i (rd_en_i),
    .sel_i   (sel),
    .dir_i   (dir_q),
    .lat_i   (lat_q),
    .sync_i  (sync_q),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/gpio_share_port_chk.sv
module gpio_share_port_chk #(
  parameter int unsigned  W         = 16,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic         rd_en_i,
  input logic [1:0]   sel_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] periph_en_i,
  input logic [W-1:0] periph_oe_i,
  input logic [W-1:0] periph_out_i,
  input logic [W-1:0] periph_in_o,
  input logic [W-1:0] pin_in_i,
  input logic [W-1:0] pin_out_o,
  input logic [W-1:0] pin_oe_o,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] lat_q
);
  logic [W-1:0] owns, port_cand;
  logic [1:0]   since_rst;

  assign owns      = periph_en_i & periph_oe_i & IMPL_MASK;
  assign port_cand = ~owns & ~dir_q & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (dir_q == IMPL_MASK) && (lat_q == '0));

  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == 2'd0) |=> dir_q == ($past(wdata_i) & IMPL_MASK));

  assert_dir_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~owns & dir_q & pin_oe_o) == '0);

  assert_sel_rsvd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i || sel_i == 2'd3) |-> rdata_o == '0);

  assert_lat_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == 2'd2) |=> lat_q == ($past(wdata_i) & IMPL_MASK));

  assert_pin_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == 2'd1) |=> lat_q == ($past(wdata_i) & IMPL_MASK));

  assert_periph_own_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((owns & ~pin_oe_o) | (owns & (pin_out_o ^ periph_out_i))) == '0);

  assert_port_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((port_cand & ~pin_oe_o) | (port_cand & (pin_out_o ^ lat_q))) == '0);

  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o | pin_out_o | periph_in_o | rdata_o) & ~IMPL_MASK) == '0);

  assert_no_loop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_in_o & pin_oe_o & ~owns) == '0);

  assert_sync_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && rd_en_i && sel_i == 2'd1)
      |-> rdata_o == ($past(pin_in_i, 2) & IMPL_MASK));
endmodule

bind gpio_share_port gpio_share_port_chk #(.W(W), .IMPL_MASK(IMPL_MASK)) u_chk (.*);

// File: tb/gpio_share_port_bench.sv
module gpio_share_port_bench;
  localparam int          W      = 16;
  localparam logic [15:0] M      = 16'h7BFF;
  localparam time         CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]   sel = '0;
  logic [W-1:0] wdata = '0, p_en = '0, p_oe = '0, p_out = '0, pin_in = '0;
  logic [W-1:0] rdata, p_in, pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;

  gpio_share_port #(.W(W), .IMPL_MASK(M)) u_gpio_share_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .periph_en_i(p_en), .periph_oe_i(p_oe),
    .periph_out_i(p_out), .periph_in_o(p_in), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [W-1:0] m_dir, m_lat;
  logic [W-1:0] hist[$];

  initial begin m_dir = M; m_lat = '0; hist = '{16'h0, 16'h0}; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = M; m_lat = '0; hist = '{16'h0, 16'h0};
    end else begin
      if (wr_en) begin
        if (sel == 2'd0) m_dir = wdata & M;
        else if (sel == 2'd1 || sel == 2'd2) m_lat = wdata & M;
      end
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [W-1:0] e_oe, e_out, e_pin, e_rd, synced;
    string rtag;
    synced = hist[0];
    for (int i = 0; i < W; i++) begin
      bit impl, owned, drv;
      impl  = M[i];
      owned = impl && p_en[i] && p_oe[i];
      drv   = impl && !owned && !m_dir[i];
      e_oe[i]  = owned || drv;
      e_out[i] = !impl ? 1'b0 : (owned ? p_out[i] : m_lat[i]);
      e_pin[i] = (impl && !drv) ? synced[i] : 1'b0;
    end
    if (!rd_en) begin e_rd = '0; rtag = "R3"; end
    else case (sel)
      2'd0: begin e_rd = m_dir;      rtag = "R2"; end
      2'd1: begin e_rd = synced & M; rtag = "R5/R10"; end
      2'd2: begin e_rd = m_lat;      rtag = "R4"; end
      default: begin e_rd = '0;      rtag = "R3"; end
    endcase
    chk(rtag, rdata, e_rd);
    chk("R2/R6/R7 pin_oe", pin_oe, e_oe);
    chk("R6/R7 pin_out", pin_out, e_out);
    chk("R9 periph_in", p_in, e_pin);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    compare();
  endtask

  task automatic wr(logic [1:0] s, logic [W-1:0] d);
    wr_en = 1'b1; rd_en = 1'b0; sel = s; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] s);
    wr_en = 1'b0; rd_en = 1'b1; sel = s;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset with a write strobe pending
    wr_en = 1'b1; sel = 2'd0; wdata = 16'h0000;
    repeat (3) @(negedge clk);
    #1; compare();
    chk("R1 pin_oe in reset", pin_oe, 16'h0000);
    wr_en = 1'b0; rst_n = 1'b1;
    rd(2'd0); chk("R1 dir reset", rdata, M);
    rd(2'd2); chk("R1 latch reset", rdata, 16'h0000);

    // R2/R5: high byte outputs, latch via pin register
    wr(2'd0, 16'h00FF);
    wr(2'd1, 16'hFFA5);
    rd(2'd2); chk("R5 pin write to latch", rdata, 16'h7BA5);
    chk("R2 oe from dir", pin_oe, 16'h7B00);
    chk("R2 out from latch", pin_out, 16'h7BA5);

    // R4: direct latch write
    wr(2'd2, 16'h1234);
    rd(2'd2); chk("R4 latch readback", rdata, 16'h1234);

    // R3: reserved select and read strobe low
    rd(2'd3); chk("R3 select 3", rdata, 16'h0000);
    rd_en = 1'b0; sel = 2'd2; tick(); chk("R3 rd_en low", rdata, 16'h0000);

    // R8: unimplemented bits ignore writes
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h8400);
    rd(2'd2); chk("R8 latch masked", rdata, 16'h0000);
    rd(2'd0); chk("R8 dir masked", rdata, M);

    // R10: two-edge latency
    rd_en = 1'b1; sel = 2'd1; pin_in = 16'hFFFF;
    tick(); chk("R10 one edge", rdata, 16'h0000);
    tick(); chk("R10 two edges", rdata, M);

    // R6/R9: peripheral owns a subset, port drives the rest
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h00FF);
    p_en = 16'h0F0F; p_oe = 16'h0303; p_out = 16'h0101;
    rd(2'd1);
    chk("R6 pin_oe", pin_oe, M);
    chk("R6 pin_out", pin_out, 16'h01FD);
    chk("R6 pin still readable", rdata, M);
    chk("R9 loop-through blocked", p_in, 16'h0303);

    // R7: enabled but not asserting oe
    p_oe = 16'h0000;
    rd(2'd1);
    chk("R7 port drives", pin_oe, M);
    chk("R7 port data", pin_out, 16'h00FF);
    chk("R9 all port driven", p_in, 16'h0000);

    // R9: pins back to input, peripheral sees pins
    wr(2'd0, 16'hFFFF);
    rd(2'd1);
    chk("R9 follows pin", p_in, M);
    chk("R2 inputs not driven", pin_oe, 16'h0000);

    // random traffic with resets during writes
    for (int n = 0; n < 4000; n++) begin
      wr_en  = 1'($urandom);
      rd_en  = 1'($urandom);
      sel    = 2'($urandom);
      wdata  = 16'($urandom);
      p_en   = 16'($urandom);
      p_oe   = 16'($urandom);
      p_out  = 16'($urandom);
      if (($urandom % 4) != 0) pin_in = 16'($urandom);
      if (($urandom % 200) == 0) begin
        rst_n = 1'b0; wr_en = 1'b1;
        #1; compare();
        tick();
        chk("R1 dir after reset", m_dir, M);
        rst_n = 1'b1;
      end else begin
        tick();
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule